// File: doc/BRIEF.md
# Register-Programmed SPI Master

This block is a serial-peripheral master with a small register file on a plain 32-bit bus that has an address, a write enable, write data and combinational read data. Software chooses one of eight targets and enables its select line. It picks the clock polarity and phase, a word width of 8 or 16 bits, and separate bit orders for the outgoing and the incoming direction. It then starts a transfer by writing one word. The block shifts the word out on MOSI, collects the reply from MISO, and raises a sticky completion flag. Software reads the reply and clears the flag before it starts the next word.

SCK timing comes from an external prescaler. That prescaler supplies two single-cycle strobes: one for the leading edge of each bit and one for the trailing edge. The engine acts on them only while a word is in flight, and it sets SCK to the matching level on each strobe. A timing field can move the MISO capture one clock later than the sampling edge. This gives margin when the returning data arrives late at high bit rates.

Top module: `spim_ctrl_top`

## Requirements
- R1: After reset every select line is high, SCK is low, the completion register (0x10) reads 0, the timing register (0x18) reads 0x40 (sample field = 1), and the busy bit (bit 8 of 0x00) reads 0.
- R2: Register 0x00 holds an enable in bit 0 and a select index in bits 4:2. Select line `idx` is driven low only while the enable is 1. All other lines stay high, and all lines are high while the enable is 0.
- R3: In register 0x04, bit 11 sets the SCK idle level (polarity). Each accepted leading strobe moves SCK to the opposite level, and each accepted trailing strobe returns it to the idle level. After a word ends, SCK rests at the idle level.
- R4: Bit 12 of 0x04 selects the phase. When it is 0, the first bit is on MOSI before the first leading edge, MISO is sampled at leading edges and MOSI changes at trailing edges. When it is 1, MOSI changes at leading edges and MISO is sampled at trailing edges. All four polarity/phase pairs transfer correctly.
- R5: Bit 5 of 0x04 set gives 16-bit words and clear gives 8-bit words. An 8-bit reply reads back zero-extended from 0x0C.
- R6: Bit 13 of 0x04 set sends bit 0 of the word first. When it is clear, the top bit of the word (bit 7 or bit 15) is sent first.
- R7: Bit 14 of 0x04 set treats the first received bit as bit 0 of the reply. When it is clear, the first received bit is the top bit. This choice is independent of bit 13.
- R8: A write to 0x08 while idle starts one word, taking its low 8 or 16 bits. The reply is read from 0x0C.
- R9: Once a word completes, 0x10 reads 1 and keeps reading 1 until 0 is written to it. A nonzero write to 0x10 leaves it set.
- R10: Bit 8 of 0x00 reads 1 while a word is in flight. A write to 0x08 during that time is dropped and does not start a further word.
- R11: Bits 7:6 of 0x18 choose the MISO capture point. Values 0 and 1 capture at the clock of the sampling edge, and values 2 and 3 capture one clock later.
- R12: Edge strobes that arrive while no word is in flight leave SCK at the idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 8 | Register byte address |
| reg_we | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed register (combinational) |
| edge_lead | input | 1 | Single-cycle strobe for a leading SCK edge |
| edge_trail | input | 1 | Single-cycle strobe for a trailing SCK edge |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the target |
| spi_miso | input | 1 | Serial data from the target |
| spi_cs_n | output | 8 | Active-low target selects |

## Verification
A wrong bit counter or phase flag shows at the ports as SCK stopping at the wrong level, or as a reply that is shifted by one position. Either shows up at the first completion readback, within one word time. A wrong order or width setting corrupts the word captured by the bench target and the reply in 0x0C for that same word. A late-capture fault is exposed with a target whose data changes just after the sampling edge: the reply then differs by exactly one bit position between capture points 1 and 2. Select decode and sticky-flag faults show on the very next bus read or select-line sample.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam int REG_W    = 32;
    localparam int NUM_CS   = 8;
    localparam int WORD_MAX = 16;

    // register byte offsets
    localparam int OFS_CTRL  = 'h00;
    localparam int OFS_CFG   = 'h04;
    localparam int OFS_DOUT  = 'h08;
    localparam int OFS_DIN   = 'h0C;
    localparam int OFS_CAUSE = 'h10;
    localparam int OFS_TIME  = 'h18;

    // field positions
    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_IDX_LSB  = 2;
    localparam int CTRL_BUSY_BIT = 8;
    localparam int CFG_WIDE_BIT  = 5;
    localparam int CFG_CPOL_BIT  = 11;
    localparam int CFG_CPHA_BIT  = 12;
    localparam int CFG_TXLSB_BIT = 13;
    localparam int CFG_RXLSB_BIT = 14;
    localparam int TIME_SMP_LSB  = 6;

    typedef struct packed {
        logic rx_lsb;
        logic tx_lsb;
        logic cpha;
        logic cpol;
        logic wide;
    } spi_cfg_t;

    typedef enum logic [1:0] {
        SMP_EDGE0 = 2'd0,
        SMP_EDGE  = 2'd1,
        SMP_LATE  = 2'd2,
        SMP_LATE3 = 2'd3
    } smp_sel_e;

    function automatic spi_cfg_t cfg_from_word(logic [REG_W-1:0] w);
        spi_cfg_t c;
        c.rx_lsb = w[CFG_RXLSB_BIT];
        c.tx_lsb = w[CFG_TXLSB_BIT];
        c.cpha   = w[CFG_CPHA_BIT];
        c.cpol   = w[CFG_CPOL_BIT];
        c.wide   = w[CFG_WIDE_BIT];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] cfg_to_word(spi_cfg_t c);
        logic [REG_W-1:0] w;
        w = '0;
        w[CFG_RXLSB_BIT] = c.rx_lsb;
        w[CFG_TXLSB_BIT] = c.tx_lsb;
        w[CFG_CPHA_BIT]  = c.cpha;
        w[CFG_CPOL_BIT]  = c.cpol;
        w[CFG_WIDE_BIT]  = c.wide;
        return w;
    endfunction

    function automatic logic smp_is_late(smp_sel_e s);
        return s[1];
    endfunction

endpackage

// File: rtl/spim_regs.sv
module spim_regs
    import spim_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int N_CS     = NUM_CS,
    parameter int W_MAX    = WORD_MAX,
    localparam int IDX_W   = $clog2(N_CS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output spi_cfg_t          cfg_o,
    output logic              cs_en_o,
    output logic [IDX_W-1:0]  cs_idx_o,
    output logic              smp_late_o,
    output logic              start_o,
    output logic [W_MAX-1:0]  tx_word_o,
    input  logic              busy_i,
    input  logic              done_i,
    input  logic [W_MAX-1:0]  rx_word_i
);

    logic sel_ctrl, sel_cfg, sel_dout, sel_din, sel_cause, sel_time;
    logic cause_q;
    smp_sel_e smp_q;

    assign sel_ctrl  = (addr == ADDR_W'(OFS_CTRL));
    assign sel_cfg   = (addr == ADDR_W'(OFS_CFG));
    assign sel_dout  = (addr == ADDR_W'(OFS_DOUT));
    assign sel_din   = (addr == ADDR_W'(OFS_DIN));
    assign sel_cause = (addr == ADDR_W'(OFS_CAUSE));
    assign sel_time  = (addr == ADDR_W'(OFS_TIME));

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_en_o  <= 1'b0;
            cs_idx_o <= '0;
            cfg_o    <= '0;
            smp_q    <= SMP_EDGE;
            cause_q  <= 1'b0;
        end else begin
            if (we && sel_ctrl) begin
                cs_en_o  <= wdata[CTRL_EN_BIT];
                cs_idx_o <= wdata[CTRL_IDX_LSB +: IDX_W];
            end
            if (we && sel_cfg)
                cfg_o <= cfg_from_word(wdata);
            if (we && sel_time)
                smp_q <= smp_sel_e'(wdata[TIME_SMP_LSB +: 2]);
            if (we && sel_cause && (wdata == '0))
                cause_q <= 1'b0;
            if (done_i)
                cause_q <= 1'b1;
        end
    end

    assign start_o    = we && sel_dout;
    assign tx_word_o  = wdata[W_MAX-1:0];
    assign smp_late_o = smp_is_late(smp_q);

    always_comb begin
        rdata = '0;
        if (sel_ctrl) begin
            rdata[CTRL_EN_BIT]            = cs_en_o;
            rdata[CTRL_IDX_LSB +: IDX_W]  = cs_idx_o;
            rdata[CTRL_BUSY_BIT]          = busy_i;
        end
        if (sel_cfg)   rdata = cfg_to_word(cfg_o);
        if (sel_din)   rdata[W_MAX-1:0] = rx_word_i;
        if (sel_cause) rdata[0] = cause_q;
        if (sel_time)  rdata[TIME_SMP_LSB +: 2] = smp_q;
    end

    // R9: completion is recorded on the cycle after the engine finishes
    a_r9_cause_set: assert property (@(posedge clk) disable iff (rst)
        done_i |=> cause_q);

    // R9: only a zero write to the cause register drops the flag
    a_r9_cause_sticky: assert property (@(posedge clk) disable iff (rst)
        (cause_q && !(we && sel_cause && (wdata == '0))) |=> cause_q);

endmodule

// File: rtl/spim_cs_decode.sv
module spim_cs_decode #(
    parameter int N_CS   = 8,
    localparam int IDX_W = $clog2(N_CS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [N_CS-1:0]  cs_n_o
);

    for (genvar i = 0; i < N_CS; i++) begin : g_line
        assign cs_n_o[i] = !(en_i && (idx_i == IDX_W'(i)));
    end

    // R2: never more than one target selected
    a_r2_cs_onehot0: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n_o));

endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
    import spim_pkg::*;
#(
    parameter int W_MAX  = WORD_MAX,
    localparam int HALF  = W_MAX / 2,
    localparam int CNT_W = $clog2(W_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  spi_cfg_t         cfg_i,
    input  logic             smp_late_i,
    input  logic             start_i,
    input  logic [W_MAX-1:0] tx_word_i,
    input  logic             lead_i,
    input  logic             trail_i,
    input  logic             miso_i,
    output logic             sck_o,
    output logic             mosi_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [W_MAX-1:0] rx_word_o
);

    logic             busy_q, phase_q, first_q, pend_q, sck_q, done_q;
    logic [CNT_W-1:0] cnt_q;
    logic [W_MAX-1:0] tx_q, rx_q;
    logic             lead_ok, trail_ok, smp_ev, shift_ev;
    logic [CNT_W-1:0] nbits;
    logic [W_MAX-1:0] tx_load, rx_next;

    assign lead_ok  = busy_q && !phase_q && lead_i && (cnt_q != '0);
    assign trail_ok = busy_q && phase_q && trail_i;
    assign smp_ev   = cfg_i.cpha ? trail_ok : lead_ok;
    assign shift_ev = cfg_i.cpha ? (lead_ok && !first_q) : trail_ok;
    assign nbits    = cfg_i.wide ? CNT_W'(W_MAX) : CNT_W'(HALF);

    always_comb begin
        if (cfg_i.wide)
            tx_load = tx_word_i;
        else if (cfg_i.tx_lsb)
            tx_load = {{HALF{1'b0}}, tx_word_i[HALF-1:0]};
        else
            tx_load = {tx_word_i[HALF-1:0], {HALF{1'b0}}};
    end

    assign rx_next = cfg_i.rx_lsb ? {miso_i, rx_q[W_MAX-1:1]}
                                  : {rx_q[W_MAX-2:0], miso_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            phase_q <= 1'b0;
            first_q <= 1'b0;
            pend_q  <= 1'b0;
            sck_q   <= 1'b0;
            done_q  <= 1'b0;
            cnt_q   <= '0;
            tx_q    <= '0;
            rx_q    <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                sck_q <= cfg_i.cpol;
                if (start_i) begin
                    busy_q  <= 1'b1;
                    cnt_q   <= nbits;
                    tx_q    <= tx_load;
                    rx_q    <= '0;
                    phase_q <= 1'b0;
                    first_q <= 1'b1;
                    pend_q  <= 1'b0;
                end
            end else begin
                if (lead_ok) begin
                    sck_q   <= ~cfg_i.cpol;
                    phase_q <= 1'b1;
                    first_q <= 1'b0;
                end
                if (trail_ok) begin
                    sck_q   <= cfg_i.cpol;
                    phase_q <= 1'b0;
                    cnt_q   <= cnt_q - 1'b1;
                end
                if (shift_ev)
                    tx_q <= cfg_i.tx_lsb ? {1'b0, tx_q[W_MAX-1:1]}
                                         : {tx_q[W_MAX-2:0], 1'b0};
                if (pend_q) begin
                    rx_q   <= rx_next;
                    pend_q <= 1'b0;
                end
                if (smp_ev) begin
                    if (smp_late_i) pend_q <= 1'b1;
                    else            rx_q   <= rx_next;
                end
                if ((cnt_q == '0) && !pend_q) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign sck_o  = sck_q;
    assign mosi_o = cfg_i.tx_lsb ? tx_q[0] : tx_q[W_MAX-1];
    assign busy_o = busy_q;
    assign done_o = done_q;

    always_comb begin
        if (cfg_i.wide)        rx_word_o = rx_q;
        else if (cfg_i.rx_lsb) rx_word_o = {{HALF{1'b0}}, rx_q[W_MAX-1:HALF]};
        else                   rx_word_o = {{HALF{1'b0}}, rx_q[HALF-1:0]};
    end

    // R8: an accepted start makes the engine busy
    a_r8_start_busy: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_q) |=> busy_q);

    // R10: a start request during a word does not end or restart it
    a_r10_no_restart: assert property (@(posedge clk) disable iff (rst)
        (start_i && busy_q && (cnt_q != '0)) |=> busy_q);

    // R11: a delayed capture is taken exactly one clock later
    a_r11_late_one_cycle: assert property (@(posedge clk) disable iff (rst)
        pend_q |=> !pend_q);

    // R12: with no word in flight SCK follows the idle level
    a_r12_idle_sck: assert property (@(posedge clk) disable iff (rst)
        !busy_q |=> (sck_q == $past(cfg_i.cpol)));

endmodule

// File: rtl/spim_ctrl_top.sv
module spim_ctrl_top
    import spim_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int N_CS   = NUM_CS,
    parameter int W_MAX  = WORD_MAX,
    localparam int IDX_W = $clog2(N_CS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              edge_lead,
    input  logic              edge_trail,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [N_CS-1:0]   spi_cs_n
);

    spi_cfg_t         cfg;
    logic             cs_en, smp_late, start, busy, done;
    logic [IDX_W-1:0] cs_idx;
    logic [W_MAX-1:0] tx_word, rx_word;

    spim_regs #(.ADDR_W(ADDR_W), .N_CS(N_CS), .W_MAX(W_MAX)) regs_i (
        .clk, .rst,
        .addr(reg_addr), .we(reg_we), .wdata(reg_wdata), .rdata(reg_rdata),
        .cfg_o(cfg), .cs_en_o(cs_en), .cs_idx_o(cs_idx),
        .smp_late_o(smp_late), .start_o(start), .tx_word_o(tx_word),
        .busy_i(busy), .done_i(done), .rx_word_i(rx_word)
    );

    spim_cs_decode #(.N_CS(N_CS)) csdec_i (
        .clk, .rst, .en_i(cs_en), .idx_i(cs_idx), .cs_n_o(spi_cs_n)
    );

    spim_shifter #(.W_MAX(W_MAX)) shift_i (
        .clk, .rst, .cfg_i(cfg), .smp_late_i(smp_late), .start_i(start),
        .tx_word_i(tx_word), .lead_i(edge_lead), .trail_i(edge_trail),
        .miso_i(spi_miso), .sck_o(spi_sck), .mosi_o(spi_mosi),
        .busy_o(busy), .done_o(done), .rx_word_o(rx_word)
    );

endmodule

// File: tb/spim_ctrl_top_tb_top.sv
module spim_ctrl_top_tb_top;

    localparam logic [7:0] A_CTRL = 8'h00, A_CFG = 8'h04, A_DOUT = 8'h08,
                           A_DIN = 8'h0C, A_CAUSE = 8'h10, A_TIME = 8'h18;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        edge_lead = 1'b0, edge_trail = 1'b0;
    logic        spi_sck, spi_mosi;
    logic        spi_miso = 1'b0;
    logic [7:0]  spi_cs_n;

    always #5 clk = ~clk;

    spim_ctrl_top dut_i (
        .clk, .rst, .reg_addr, .reg_we, .reg_wdata, .reg_rdata,
        .edge_lead, .edge_trail, .spi_sck, .spi_mosi, .spi_miso, .spi_cs_n
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // prescaler stand-in: leading and trailing strobes every 8 clocks
    initial begin
        int c = 0;
        forever begin
            @(negedge clk);
            edge_lead  = (c == 1);
            edge_trail = (c == 5);
            c = (c + 1) % 8;
        end
    end

    // target model
    bit [15:0] slv_word, slv_wire;
    int        slv_n, slv_out_idx, slv_smp_idx;
    bit        slv_cpol, slv_cpha, slv_rx_lsb, slv_late;
    logic      sck_prev = 1'b0;

    function automatic bit wire_bit(int k);
        if (k >= slv_n) return 1'b0;
        return slv_word[slv_rx_lsb ? k : slv_n - 1 - k];
    endfunction

    initial begin
        forever begin
            @(negedge clk);
            if (spi_sck !== sck_prev) begin
                bit lead_e, smp_e;
                lead_e = (spi_sck != slv_cpol);
                smp_e  = slv_cpha ? !lead_e : lead_e;
                if (smp_e) begin
                    if (slv_smp_idx < 16) slv_wire[slv_smp_idx] = spi_mosi;
                    if (slv_late) spi_miso = wire_bit(slv_smp_idx);
                    slv_smp_idx++;
                end else if (!slv_late) begin
                    if (slv_cpha) begin
                        spi_miso = wire_bit(slv_out_idx);
                        slv_out_idx++;
                    end else begin
                        slv_out_idx++;
                        spi_miso = wire_bit(slv_out_idx);
                    end
                end
            end
            sck_prev = spi_sck;
        end
    end

    task automatic bus_wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic bus_rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_we = 1'b0;
        #1 d = reg_rdata;
    endtask

    // scoreboard
    typedef struct {
        bit [15:0] exp_rx;
        bit [15:0] exp_tx;
        string     tag;
    } sb_item_t;

    sb_item_t  sb_q[$];
    bit        obs_valid = 1'b0;
    bit [15:0] obs_rx, obs_tx;

    initial begin
        forever begin
            sb_item_t it;
            wait (obs_valid);
            if (sb_q.size() == 0) begin
                chk(1'b0, "R8", "scoreboard underflow", 0, 1);
            end else begin
                it = sb_q.pop_front();
                chk(obs_rx == it.exp_rx, it.tag, "reply word", obs_rx, it.exp_rx);
                chk(obs_tx == it.exp_tx, it.tag, "word seen by target", obs_tx, it.exp_tx);
            end
            obs_valid = 1'b0;
        end
    end

    task automatic xfer(bit cpol, bit cpha, bit wide, bit txl, bit rxl,
                        bit [15:0] tx, bit [15:0] sw, bit late, bit shift_exp,
                        bit poke, bit sticky, string tag);
        logic [31:0] rd;
        sb_item_t    it;
        int          n;
        bit          got;
        n = wide ? 16 : 8;
        bus_wr(A_CFG, (32'(cpol) << 11) | (32'(cpha) << 12) | (32'(wide) << 5)
                      | (32'(txl) << 13) | (32'(rxl) << 14));
        repeat (3) @(negedge clk);
        slv_cpol = cpol; slv_cpha = cpha; slv_rx_lsb = rxl; slv_late = late;
        slv_n = n; slv_word = sw; slv_wire = '0;
        slv_out_idx = 0; slv_smp_idx = 0;
        spi_miso = (late || cpha) ? 1'b0 : wire_bit(0);
        it.exp_rx = (n == 16) ? sw : {8'h00, sw[7:0]};
        if (shift_exp) it.exp_rx = it.exp_rx >> 1;
        it.exp_tx = (n == 16) ? tx : {8'h00, tx[7:0]};
        it.tag = tag;
        sb_q.push_back(it);
        bus_wr(A_DOUT, 32'(tx));
        if (poke) begin
            repeat (10) @(negedge clk);
            bus_rd(A_CTRL, rd);
            chk(rd[8] == 1'b1, "R10", "busy bit during word", rd[8], 1);
            bus_wr(A_DOUT, 32'h0000_FFFF);
        end
        got = 1'b0;
        for (int i = 0; i < 3000 && !got; i++) begin
            bus_rd(A_CAUSE, rd);
            if (rd != 0) got = 1'b1;
        end
        chk(got, "R9", "completion flag raised", got, 1);
        bus_rd(A_DIN, rd);
        obs_rx = rd[15:0];
        obs_tx = '0;
        for (int k = 0; k < n; k++) begin
            if (txl) obs_tx[k] = slv_wire[k];
            else     obs_tx[n-1-k] = slv_wire[k];
        end
        obs_valid = 1'b1;
        wait (!obs_valid);
        @(negedge clk);
        chk(spi_sck == cpol, "R3", "SCK idle level after word", spi_sck, cpol);
        if (poke) begin
            repeat (40) @(negedge clk);
            bus_rd(A_CTRL, rd);
            chk(rd[8] == 1'b0, "R10", "no second word after dropped write", rd[8], 0);
            chk(spi_sck == cpol, "R12", "SCK stays idle with strobes running", spi_sck, cpol);
        end
        if (sticky) begin
            bus_rd(A_CAUSE, rd);
            chk(rd == 1, "R9", "flag still set on second read", rd, 1);
            bus_wr(A_CAUSE, 32'h5);
            bus_rd(A_CAUSE, rd);
            chk(rd == 1, "R9", "nonzero write leaves flag", rd, 1);
        end
        bus_wr(A_CAUSE, 32'h0);
        bus_rd(A_CAUSE, rd);
        chk(rd == 0, "R9", "zero write clears flag", rd, 0);
    endtask

    initial begin
        repeat (200000 - 50000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R8 watchdog expired actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(spi_cs_n == 8'hFF, "R1", "selects after reset", spi_cs_n, 8'hFF);
        chk(spi_sck == 1'b0, "R1", "SCK after reset", spi_sck, 0);
        bus_rd(A_CAUSE, rd);
        chk(rd == 0, "R1", "cause after reset", rd, 0);
        bus_rd(A_TIME, rd);
        chk(rd == 32'h40, "R1", "timing after reset", rd, 32'h40);
        bus_rd(A_CTRL, rd);
        chk(rd[8] == 1'b0, "R1", "busy after reset", rd[8], 0);

        // R2 select decode
        bus_wr(A_CTRL, 32'h1 | (32'd5 << 2));
        chk(spi_cs_n == 8'hDF, "R2", "select 5 enabled", spi_cs_n, 8'hDF);
        bus_wr(A_CTRL, 32'd5 << 2);
        chk(spi_cs_n == 8'hFF, "R2", "enable cleared", spi_cs_n, 8'hFF);
        bus_wr(A_CTRL, 32'h1);
        chk(spi_cs_n == 8'hFE, "R2", "select 0 enabled", spi_cs_n, 8'hFE);
        bus_wr(A_CTRL, 32'h1 | (32'd7 << 2));
        chk(spi_cs_n == 8'h7F, "R2", "select 7 enabled", spi_cs_n, 8'h7F);
        bus_wr(A_CTRL, 32'h1 | (32'd3 << 2));
        chk(spi_cs_n == 8'hF7, "R2", "select 3 enabled", spi_cs_n, 8'hF7);

        // R4 all four modes, 8-bit MSB first
        xfer(0, 0, 0, 0, 0, 16'h00A5, 16'h003C, 0, 0, 0, 0, "R4_mode0");
        xfer(0, 1, 0, 0, 0, 16'h00A6, 16'h003D, 0, 0, 0, 0, "R4_mode1");
        xfer(1, 0, 0, 0, 0, 16'h00A7, 16'h003E, 0, 0, 0, 0, "R4_mode2");
        xfer(1, 1, 0, 0, 0, 16'h00A8, 16'h003F, 0, 0, 0, 0, "R4_mode3");

        // R5 16-bit words
        xfer(0, 0, 1, 0, 0, 16'hBEEF, 16'h1234, 0, 0, 0, 0, "R5_wide_mode0");
        xfer(1, 1, 1, 1, 1, 16'h8001, 16'h4C21, 0, 0, 0, 0, "R5_wide_lsb_mode3");

        // R6 / R7 independent orders
        xfer(0, 1, 0, 1, 0, 16'h001E, 16'h00B4, 0, 0, 0, 0, "R6_tx_lsb_only");
        xfer(1, 0, 0, 0, 1, 16'h00C3, 16'h0059, 0, 0, 0, 0, "R7_rx_lsb_only");

        // R8 / R9 sticky flag, R10 dropped write during word
        xfer(0, 0, 0, 0, 0, 16'h0071, 16'h00E2, 0, 0, 0, 1, "R8_sticky");
        xfer(0, 0, 0, 0, 0, 16'h0096, 16'h0069, 0, 0, 1, 0, "R10_busy_write");

        // R11 capture point with a late target in mode 3
        bus_wr(A_TIME, 32'd2 << 6);
        bus_rd(A_TIME, rd);
        chk(rd == 32'h80, "R11", "timing readback", rd, 32'h80);
        xfer(1, 1, 0, 0, 0, 16'h005A, 16'h00D3, 1, 0, 0, 0, "R11_late_capture");
        bus_wr(A_TIME, 32'd1 << 6);
        xfer(1, 1, 0, 0, 0, 16'h005A, 16'h00D3, 1, 1, 0, 0, "R11_edge_capture");

        repeat (5) @(negedge clk);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule